// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address sequence for one read or write burst of a synchronous DRAM-style memory. A start command carries a start column, a three-bit burst length code and an ordering select. From the edge that accepts the command, the block presents one column address per rising clock edge, with a valid flag. It marks the final address of a finite burst with a last-beat flag.

Two orderings are supported. Sequential ordering counts the low column bits upward and wraps inside the aligned block that the burst length defines. Interleaved ordering XORs the low column bits with the beat number. A full-page length is available for sequential bursts only. It walks all 512 columns, wraps from 511 to 0, and runs until it is stopped.

A burst can be stopped by a terminate request. It can also be restarted from a new column by a fresh start command on any cycle, with no alignment rule.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, colValid and lastBeat are 0 and stay 0 until a start command is accepted.
- R2: Length codes give these burst lengths: 000 gives 1, 001 gives 2, 010 gives 4, 011 gives 8, and 111 with sequential ordering gives full page.
- R3: In sequential ordering (interleave=0), beat n of a burst of length L (a power of two) from start column S is (S with its low log2(L) bits replaced by the low log2(L) bits of S+n); the upper bits are held.
- R4: In interleaved ordering (interleave=1), beat n is S XOR n, where n is below L, so only the low log2(L) bits change.
- R5: A full-page burst outputs (S+n) mod 512 on beat n. It wraps from 511 to 0, keeps colValid high and never raises lastBeat until it is terminated or restarted.
- R6: Code 111 with interleave=1, and the reserved codes 100, 101 and 110 in either ordering, all give a burst length of 8.
- R7: lastBeat is 1 exactly on beat L-1 of a finite burst. In the cycle after the last beat, colValid is 0 unless a new start was accepted.
- R8: When terminate is high at an edge during a burst and startValid is low, colValid is 0 after that edge. When no burst is active, terminate has no effect.
- R9: A start command accepted during a burst restarts at beat 0 from the new column, with the new length and ordering. A start command wins over a simultaneous terminate.
- R10: Beat 0 (the start column itself) is presented in the cycle after the edge that accepts startValid. Each later edge advances exactly one beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| startValid | input | 1 | Start command; begins or restarts a burst |
| startCol | input | 9 | Start column of the burst |
| lenCode | input | 3 | Burst length code |
| interleave | input | 1 | 0 selects sequential ordering, 1 selects interleaved ordering |
| terminate | input | 1 | Stops a burst in progress |
| colOut | output | 9 | Current column address |
| colValid | output | 1 | colOut holds a beat of an active burst |
| lastBeat | output | 1 | Current beat is the final one of a finite burst |

## Verification
The bench sweeps start columns across the whole column range with every length code and both orderings. Start columns with nonzero low bits test the in-block wrap. A design that carried into the upper bits, or that added where it should XOR, would then emit a column outside the aligned block. Full-page runs start near column 511, which exposes a counter that stops or saturates instead of wrapping to 0. The illegal interleaved full-page code is included to catch a burst that never ends. Terminate and restart are applied in the middle of bursts, and together on one cycle, to expose a design that runs on for an extra beat, keeps the old beat count, or lets terminate override the new command.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  // Burst length codes
  localparam logic [2:0] LEN_1    = 3'b000;
  localparam logic [2:0] LEN_2    = 3'b001;
  localparam logic [2:0] LEN_4    = 3'b010;
  localparam logic [2:0] LEN_8    = 3'b011;
  localparam logic [2:0] LEN_FULL = 3'b111;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;   // capture start column, mask and ordering, clear beat count
    logic step;   // advance one beat
  } ctrl_strobe_t;
endpackage

// File: rtl/bcs_len_decode.sv
module bcs_len_decode #(
  parameter int COL_W    = 9,
  parameter int FIN_LOG2 = 3   // log2 of the longest finite burst
) (
  input  logic [2:0]       lenCode,
  input  logic             interleave,
  output logic [COL_W-1:0] lowMask,
  output logic             fullPage
);
  import bcs_pkg::*;

  logic [COL_W-1:0] finMask;
  int               lenLog2;

  always_comb begin
    fullPage = (lenCode == LEN_FULL) && !interleave;
    // Reserved codes and the illegal interleaved full page fall back to the longest finite length
    lenLog2  = lenCode[2] ? FIN_LOG2 : int'(lenCode[1:0]);
  end

  for (genvar i = 0; i < COL_W; i++) begin : g_mask
    assign finMask[i] = (i < lenLog2);
  end

  assign lowMask = fullPage ? {COL_W{1'b1}} : finMask;
endmodule

// File: rtl/bcs_datapath.sv
module bcs_datapath #(
  parameter int COL_W = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  bcs_pkg::ctrl_strobe_t strobe,
  input  logic [COL_W-1:0]      startCol,
  input  logic [COL_W-1:0]      maskIn,
  input  logic                  interleaveIn,
  output logic [COL_W-1:0]      colOut,
  output logic                  atEnd
);
  logic [COL_W-1:0] baseCol;
  logic [COL_W-1:0] beatCnt;
  logic [COL_W-1:0] lowMask;
  logic             ilvMode;
  logic [COL_W-1:0] seqCol;
  logic [COL_W-1:0] ilvCol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      baseCol <= '0;
      beatCnt <= '0;
      lowMask <= '0;
      ilvMode <= 1'b0;
    end else if (strobe.load) begin
      baseCol <= startCol;
      beatCnt <= '0;
      lowMask <= maskIn;
      ilvMode <= interleaveIn;
    end else if (strobe.step) begin
      beatCnt <= beatCnt + 1'b1;
    end
  end

  always_comb begin
    seqCol = (baseCol & ~lowMask) | ((baseCol + beatCnt) & lowMask);
    ilvCol = baseCol ^ (beatCnt & lowMask);
    colOut = ilvMode ? ilvCol : seqCol;
    atEnd  = (beatCnt == lowMask);
  end
endmodule

// File: rtl/bcs_ctrl.sv
module bcs_ctrl (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  startValid,
  input  logic                  terminate,
  input  logic                  fullPageIn,
  input  logic                  atEnd,
  output bcs_pkg::ctrl_strobe_t strobe,
  output logic                  colValid,
  output logic                  lastBeat
);
  logic active;
  logic fullPage;
  logic finalBeat;

  assign finalBeat = active && !fullPage && atEnd;

  always_comb begin
    strobe.load = startValid;
    strobe.step = active && !startValid && !terminate && !finalBeat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      fullPage <= 1'b0;
    end else if (startValid) begin
      active   <= 1'b1;
      fullPage <= fullPageIn;
    end else if (terminate || finalBeat) begin
      active   <= 1'b0;
    end
  end

  assign colValid = active;
  assign lastBeat = finalBeat;
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq #(
  parameter int COL_W    = 9,
  parameter int FIN_LOG2 = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             startValid,
  input  logic [COL_W-1:0] startCol,
  input  logic [2:0]       lenCode,
  input  logic             interleave,
  input  logic             terminate,
  output logic [COL_W-1:0] colOut,
  output logic             colValid,
  output logic             lastBeat
);
  bcs_pkg::ctrl_strobe_t strobe;
  logic [COL_W-1:0]      decMask;
  logic                  decFull;
  logic                  atEnd;

  bcs_len_decode #(.COL_W(COL_W), .FIN_LOG2(FIN_LOG2)) dec_i (
    .lenCode   (lenCode),
    .interleave(interleave),
    .lowMask   (decMask),
    .fullPage  (decFull)
  );

  bcs_ctrl ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .startValid(startValid),
    .terminate (terminate),
    .fullPageIn(decFull),
    .atEnd     (atEnd),
    .strobe    (strobe),
    .colValid  (colValid),
    .lastBeat  (lastBeat)
  );

  bcs_datapath #(.COL_W(COL_W)) dp_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .startCol    (startCol),
    .maskIn      (decMask),
    .interleaveIn(interleave),
    .colOut      (colOut),
    .atEnd       (atEnd)
  );
endmodule

// File: rtl/burst_col_seq_checker.sv
module burst_col_seq_checker #(
  parameter int COL_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             startValid,
  input logic [COL_W-1:0] startCol,
  input logic             terminate,
  input logic [COL_W-1:0] colOut,
  input logic             colValid,
  input logic             lastBeat
);
  assert_last_in_burst_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lastBeat |-> colValid);

  assert_end_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lastBeat && !startValid) |=> !colValid);

  assert_terminate_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (colValid && terminate && !startValid) |=> !colValid);

  assert_start_beat0_R10: assert property (@(posedge clk) disable iff (!rst_n)
    startValid |=> (colValid && colOut == $past(startCol)));

  assert_idle_stays_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!colValid && !startValid) |=> !colValid);
endmodule

bind burst_col_seq burst_col_seq_checker #(.COL_W(COL_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .startValid(startValid),
  .startCol  (startCol),
  .terminate (terminate),
  .colOut    (colOut),
  .colValid  (colValid),
  .lastBeat  (lastBeat)
);

// File: tb/burst_col_seq_tb.sv
module burst_col_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       startValid = 1'b0;
  logic [8:0] startCol = '0;
  logic [2:0] lenCode = '0;
  logic       interleave = 1'b0;
  logic       terminate = 1'b0;
  logic [8:0] colOut;
  logic       colValid;
  logic       lastBeat;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  burst_col_seq dut_i (
    .clk(clk), .rst_n(rst_n), .startValid(startValid), .startCol(startCol),
    .lenCode(lenCode), .interleave(interleave), .terminate(terminate),
    .colOut(colOut), .colValid(colValid), .lastBeat(lastBeat)
  );

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Burst length from the requirements (R2, R6); 0 means full page
  function automatic int expLen(int code, int il);
    if (code == 7 && il == 0) return 0;
    if (code >= 4) return 8;
    return 1 << code;
  endfunction

  function automatic int expCol(int s, int n, int len, int il);
    int m = len - 1;
    if (il != 0) return s ^ (n & m);
    return (s & ~m & 511) | ((s + n) & m);
  endfunction

  // Drive a start command; return at the negedge where beat 0 is shown
  task automatic startBurst(int col, int code, int il);
    @(negedge clk);
    startValid = 1'b1;
    startCol   = 9'(col);
    lenCode    = 3'(code);
    interleave = il[0];
    @(negedge clk);
    startValid = 1'b0;
  endtask

  task automatic runFinite(int col, int code, int il);
    int len = expLen(code, il);
    string rq = (il != 0) ? "R4" : "R3";
    if (code >= 4) rq = "R6";
    startBurst(col, code, il);
    for (int n = 0; n < len; n++) begin
      check({rq, " col"}, int'(colOut), expCol(col, n, len, il));
      check("R10 valid", int'(colValid), 1);
      check("R7 last", int'(lastBeat), (n == len - 1) ? 1 : 0);
      @(negedge clk);
    end
    check("R7 ends", int'(colValid), 0);
  endtask

  initial begin
    #1600000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 valid", int'(colValid), 0);
    check("R1 last", int'(lastBeat), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle", int'(colValid), 0);

    // R8: terminate while idle has no effect
    terminate = 1'b1;
    @(negedge clk);
    terminate = 1'b0;
    check("R8 idle term", int'(colValid), 0);

    // R2 R3 R4 R6 R7 R10 sweep
    for (int col = 0; col < 512; col += 7) begin
      for (int code = 0; code < 8; code++) begin
        for (int il = 0; il < 2; il++) begin
          if (!(code == 7 && il == 0)) runFinite(col, code, il);
        end
      end
    end

    // R5 full page wrap
    for (int k = 0; k < 3; k++) begin
      int s = 505 + k * 3;
      startBurst(s, 7, 0);
      for (int n = 0; n < 530; n++) begin
        check("R5 col", int'(colOut), (s + n) % 512);
        check("R5 valid", int'(colValid), 1);
        check("R5 nolast", int'(lastBeat), 0);
        @(negedge clk);
      end
      terminate = 1'b1;
      check("R5 col before term", int'(colOut), (s + 530) % 512);
      @(negedge clk);
      terminate = 1'b0;
      check("R8 full term", int'(colValid), 0);
    end

    // R8: terminate mid burst
    startBurst(40, 3, 0);
    @(negedge clk);
    @(negedge clk);
    check("R8 pre", int'(colOut), expCol(40, 2, 8, 0));
    terminate = 1'b1;
    @(negedge clk);
    terminate = 1'b0;
    check("R8 stop", int'(colValid), 0);
    check("R8 stop last", int'(lastBeat), 0);

    // R9: restart mid burst, new length and ordering
    startBurst(100, 3, 0);
    @(negedge clk);
    @(negedge clk);
    startValid = 1'b1;
    startCol   = 9'd203;
    lenCode    = 3'd2;
    interleave = 1'b1;
    terminate  = 1'b1;   // start must win
    @(negedge clk);
    startValid = 1'b0;
    terminate  = 1'b0;
    for (int n = 0; n < 4; n++) begin
      check("R9 col", int'(colOut), expCol(203, n, 4, 1));
      check("R9 valid", int'(colValid), 1);
      check("R9 last", int'(lastBeat), (n == 3) ? 1 : 0);
      @(negedge clk);
    end
    check("R9 end", int'(colValid), 0);

    // R9: restart on the last beat
    startBurst(17, 1, 0);
    @(negedge clk);
    check("R9 last pre", int'(lastBeat), 1);
    startValid = 1'b1;
    startCol   = 9'd300;
    lenCode    = 3'd0;
    interleave = 1'b0;
    @(negedge clk);
    startValid = 1'b0;
    check("R9 relast col", int'(colOut), 300);
    check("R9 relast len1", int'(lastBeat), 1);
    @(negedge clk);
    check("R9 relast end", int'(colValid), 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule